// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus and clears a bus left in an unknown state by an interrupted transfer, a power loss or a system reset. A target that was cut off halfway through a byte may still be holding the data line low and waiting for more clocks. When triggered, the sequencer plays out a fixed pattern: a start condition, nine clock pulses with the data line left floating, a second start, and then a stop. Any target that was stuck mid-byte finishes its byte, sees the start/stop pair, and returns to idle.

Both lines are driven as open-drain enables. When an enable is 1, the matching line is pulled low. When it is 0, the line is released, and the external pull-up brings it high. Every interval is a parameter counted in system-clock cycles, so the same block covers any bus speed. Once the bus-free time after the stop has elapsed, the block reports completion with a one-cycle pulse. A trigger that arrives while a sequence is running is dropped.

Top module: `bus_recover_seq`

## Requirements
- R1: During reset and in idle, `scl_oe`, `sda_oe`, `busy` and `done` are all 0 (both lines released).
- R2: A trigger sampled in idle is followed by both lines released for `SETUP_START_CYC` cycles. Then `sda_oe` is set with SCL still released for `HOLD_START_CYC` cycles (the first start). Then SCL is pulled low for one guard cycle while SDA is still held low.
- R3: After the guard cycle, SCL alternates low for `LOW_CYC` cycles and released for `HIGH_CYC` cycles, giving exactly `NUM_PULSES` (nine) released pulses. A final low of `LOW_CYC` cycles follows the last pulse.
- R4: `sda_oe` changes while SCL is released in both neighbouring cycles only at the two start edges and the one stop edge. SDA is released for the whole of every clock pulse.
- R5: After the final low, both lines are released for `SETUP_START_CYC` cycles. Then `sda_oe` is set for max(`HOLD_START_CYC`, `SETUP_STOP_CYC`) cycles with SCL released (the second start). Releasing SDA after that forms the stop.
- R6: After the stop, both lines stay released for `BUS_FREE_CYC` cycles. Then `done` is 1 for exactly one cycle. `busy` is 1 from the first cycle after the trigger up to and including the `done` cycle.
- R7: A trigger sampled while `busy` is 1 has no effect, including a trigger in the same cycle as `done`. The running sequence keeps its exact waveform and length, and no second sequence follows.
- R8: A trigger sampled in the first idle cycle after `done` starts a complete new sequence, identical to the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigger | input | 1 | Request to run one recovery sequence; sampled on each clock edge |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | A sequence is in progress, including the done cycle |
| done | output | 1 | One-cycle pulse once the bus-free time after the stop has elapsed |

## Verification
The completion pulse and a fresh trigger can land in the same clock cycle. The block must drop that trigger, yet accept one presented a single cycle later. The bench sweeps the position of a second trigger across every cycle offset of a running sequence, from its first cycle up to two cycles past `done`. On each run it compares the full waveform of all four outputs, every cycle, with a timeline computed from the interval parameters. An offset inside the busy window, the `done` cycle included, must leave exactly one sequence. The first idle offset and later ones must produce a second, identical sequence that starts the cycle after the trigger.

// File: rtl/bus_recover_seq.sv
module bus_recover_seq #(
  parameter int SETUP_START_CYC = 30,
  parameter int HOLD_START_CYC  = 30,
  parameter int LOW_CYC         = 65,
  parameter int HIGH_CYC        = 30,
  parameter int SETUP_STOP_CYC  = 30,
  parameter int BUS_FREE_CYC    = 65,
  parameter int NUM_PULSES      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);

  localparam int STOP_HOLD = (HOLD_START_CYC > SETUP_STOP_CYC) ? HOLD_START_CYC : SETUP_STOP_CYC;
  localparam int M1 = (SETUP_START_CYC > HOLD_START_CYC) ? SETUP_START_CYC : HOLD_START_CYC;
  localparam int M2 = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int M3 = (STOP_HOLD > BUS_FREE_CYC) ? STOP_HOLD : BUS_FREE_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M12 > M3) ? M12 : M3;
  localparam int CW = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam int PW = $clog2(NUM_PULSES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SU1, ST_HD1, ST_DROP, ST_LOW, ST_HIGH, ST_SU2, ST_HD2, ST_BUF, ST_DONE
  } phase_t;

  phase_t state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [PW-1:0] npulse;
  logic          step;

  always_comb begin
    case (state)
      ST_SU1, ST_SU2: last = CW'(SETUP_START_CYC - 1);
      ST_HD1:         last = CW'(HOLD_START_CYC - 1);
      ST_LOW:         last = CW'(LOW_CYC - 1);
      ST_HIGH:        last = CW'(HIGH_CYC - 1);
      ST_HD2:         last = CW'(STOP_HOLD - 1);
      ST_BUF:         last = CW'(BUS_FREE_CYC - 1);
      default:        last = '0;
    endcase
  end

  assign step = (state != ST_IDLE) && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      npulse <= '0;
    end else if (state == ST_IDLE) begin
      cnt    <= '0;
      npulse <= '0;
      if (trigger) state <= ST_SU1;
    end else if (!step) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (state)
        ST_SU1:  state <= ST_HD1;
        ST_HD1:  state <= ST_DROP;
        ST_DROP: state <= ST_LOW;
        ST_LOW:  state <= (npulse == PW'(NUM_PULSES)) ? ST_SU2 : ST_HIGH;
        ST_HIGH: begin
          state  <= ST_LOW;
          npulse <= npulse + 1'b1;
        end
        ST_SU2:  state <= ST_HD2;
        ST_HD2:  state <= ST_BUF;
        ST_BUF:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe = (state == ST_DROP) || (state == ST_LOW);
  assign sda_oe = (state == ST_HD1) || (state == ST_DROP) || (state == ST_HD2);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);

  a_r4_sda_moves_only_at_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (state == ST_HD1 || state == ST_HD2 || state == ST_BUF));

  a_r2_start_before_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe) && npulse == '0) |-> $past(sda_oe));

  a_r3_pulse_count_at_second_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SU2) |-> (npulse == PW'(NUM_PULSES)));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r7_no_restart_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_SU1) |=> (state != ST_SU1));

  a_r1_idle_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe && !done));

endmodule

// File: tb/bus_recover_seq_test.sv
module bus_recover_seq_test;
  localparam int A = 2, B = 3, L = 4, H = 3, S = 5, F = 4, N = 9;
  localparam int E  = (B > S) ? B : S;
  localparam int TT = A + B + 1 + N*(L+H) + L + A + E + F + 1;

  logic clk = 1'b0;
  logic rst_n, trigger;
  logic scl_oe, sda_oe, busy, done;
  int vectors = 0, misses = 0;

  always #10 clk = ~clk;

  bus_recover_seq #(
    .SETUP_START_CYC(A), .HOLD_START_CYC(B), .LOW_CYC(L), .HIGH_CYC(H),
    .SETUP_STOP_CYC(S), .BUS_FREE_CYC(F), .NUM_PULSES(N)
  ) uut (
    .clk(clk), .rst_n(rst_n), .trigger(trigger),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done)
  );

  // {scl_oe, sda_oe, busy, done} at offset t of one sequence
  function automatic logic [3:0] exp_at(int t);
    int u;
    if (t < 0 || t >= TT) return 4'b0000;
    if (t < A) return 4'b0010;
    if (t < A + B) return 4'b0110;
    if (t == A + B) return 4'b1110;
    u = t - (A + B + 1);
    if (u < N*(L+H)) return ((u % (L+H)) < L) ? 4'b1010 : 4'b0010;
    u = u - N*(L+H);
    if (u < L) return 4'b1010;
    u = u - L;
    if (u < A) return 4'b0010;
    u = u - A;
    if (u < E) return 4'b0110;
    u = u - E;
    if (u < F) return 4'b0010;
    return 4'b0011;
  endfunction

  function automatic string tag_at(int t);
    if (t < A + B + 1) return "R2";
    if (t < A + B + 1 + N*(L+H) + L) return "R3";
    if (t < TT - F - 1) return "R5";
    return "R6";
  endfunction

  task automatic check(logic [3:0] got, logic [3:0] exp, string tag, int run, int t);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s run %0d offset %0d: got %b expected %b", tag, run, t, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    trigger = 1'b1;
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, busy, done}, 4'b0000, "R1 in reset", -1, 0);
    rst_n = 1'b1;
    trigger = 1'b0;
    @(negedge clk);
    check({scl_oe, sda_oe, busy, done}, 4'b0000, "R1 idle", -1, 0);

    for (int j = 0; j <= TT + 1; j++) begin
      logic ps, pd;
      int edges;
      ps = 1'b0; pd = 1'b0; edges = 0;
      trigger = 1'b1;
      for (int t = 0; t < 2*TT + 4; t++) begin
        logic [3:0] e;
        string tg;
        @(negedge clk);
        if (t < TT) begin
          e  = exp_at(t);
          tg = (j < TT && t > j) ? "R7" : tag_at(t);
        end else if (j >= TT && t >= j + 1) begin
          e  = exp_at(t - j - 1);
          tg = "R8";
        end else begin
          e  = 4'b0000;
          tg = (j < TT) ? "R7" : "R6";
        end
        check({scl_oe, sda_oe, busy, done}, e, tg, j, t);
        if (!scl_oe && !ps && (sda_oe != pd)) edges++;
        ps = scl_oe; pd = sda_oe;
        trigger = (t == j);
      end
      trigger = 1'b0;
      // R4: two start edges plus one stop edge per sequence while SCL released
      check(4'(edges), 4'((j >= TT) ? 6 : 3), "R4 sda edges with scl high", j, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule